// File: doc/BRIEF.md
# Activation Offload and Prefetch Scheduler

This control block runs one training iteration over a fixed number of layers. It moves each layer's saved input activation between fast local memory and slower host memory, and it does this through an external DMA engine. In the forward sweep, layers run in ascending order. When a layer's compute is launched, the copy of that layer's input out to host memory is launched in the same cycle; the input is only read, so the two can overlap. The next layer starts only once both the compute and the copy have finished.

In the backward sweep, layers run in descending order. At entry the block fetches back the input of the topmost layer. After that, each time backward compute of layer i is launched, it also launches the fetch of the input of layer i-1. A backward compute never starts while the fetch of its own input is still in flight.

A policy chosen at start selects which layers move data at all: every layer, only the layers flagged as convolutional, a hand-picked subset, or none. The block counts the cycles it spends stalled on transfers, separately for each sweep, and it pulses a completion flag when backward layer 0 finishes. The compute engine, the DMA engine and the memories are outside this block.

Top module: `act_xfer_sched`

## Requirements
- R1: After reset, `busy`, `iter_done`, `cmp_go` and `dma_req` are low, and both stall counters read zero.
- R2: `start` while idle latches the policy from `cfg_mode`. The encodings are 2'b00 = every layer, 2'b01 = layers whose `cfg_conv` bit is 1, 2'b10 = layers whose `cfg_enable` bit is 1, and 2'b11 = no layer. Changes to the `cfg_*` inputs after that edge have no effect on the running iteration.
- R3: The forward sweep launches compute for layers 0 up to NUM_LAYERS-1 in order, with `cmp_bwd`=0. For a policy-enabled layer, `dma_req` with `dma_fetch`=0 and `dma_layer` equal to that layer is raised in the same cycle as that layer's `cmp_go`.
- R4: A forward layer is not followed by the next launch until its offload has completed. `fwd_stall` counts every cycle in which the layer's compute has finished but its offload is still outstanding. For an offload latency Do and a compute latency C, that is max(0, Do-C+1) cycles per enabled layer.
- R5: The backward sweep launches compute for layers NUM_LAYERS-1 down to 0 with `cmp_bwd`=1. At the start of the sweep, a fetch (`dma_fetch`=1) of the top layer is issued. Together with the backward `cmp_go` of layer i>0, a fetch of layer i-1 is issued.
- R6: Backward compute of a layer is not launched while the fetch of its input is outstanding. `bwd_stall` counts those waiting cycles: Dp for the top layer's fetch, plus max(0, Dp-C) before each lower enabled layer.
- R7: A layer that the latched policy disables never appears on a DMA request, in either direction.
- R8: At most one offload and at most one fetch are outstanding at any time. A new request of a direction is issued only after the done pulse of the previous request of that direction.
- R9: One cycle after backward layer 0's compute completes, `iter_done` pulses high for exactly one cycle and the block returns to idle. A `start` pulse while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an iteration (accepted only when idle) |
| cfg_mode | input | 2 | Policy selector, latched at start |
| cfg_enable | input | NUM_LAYERS | Per-layer pick mask for the subset policy |
| cfg_conv | input | NUM_LAYERS | Per-layer convolutional flag |
| cmp_go | output | 1 | Single-cycle compute launch |
| cmp_bwd | output | 1 | Launch is for the backward sweep |
| cmp_layer | output | IDX_W | Layer being launched |
| cmp_done | input | 1 | Single-cycle compute completion |
| dma_req | output | 1 | Single-cycle transfer request |
| dma_fetch | output | 1 | 1 = host-to-local fetch, 0 = local-to-host offload |
| dma_layer | output | IDX_W | Layer whose input is transferred |
| dma_done | input | 1 | Single-cycle transfer completion |
| dma_done_fetch | input | 1 | Direction of the completed transfer |
| busy | output | 1 | Iteration in progress |
| iter_done | output | 1 | Completion pulse |
| fwd_stall | output | CNT_W | Saturating forward stall-cycle count |
| bwd_stall | output | CNT_W | Saturating backward stall-cycle count |

## Verification
All outputs are decoded from state, so a launch or request becomes visible in the cycle after the edge that entered its state. The bench's responders observe at the falling edge and return each done pulse exactly C or D cycles after the request. Because of this, the stall totals can be predicted in closed form (max(0, Do-C+1) per forward layer, Dp and max(0, Dp-C) in the backward sweep), and they are compared only after `iter_done` has been seen. The launch order, the per-layer request counts and the no-overlap rules are checked at every falling edge where a launch or request appears.

// File: rtl/osch_pkg.sv
package osch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD_ISSUE,
        ST_FWD_RUN,
        ST_BWD_PRE,
        ST_BWD_WAIT,
        ST_BWD_RUN,
        ST_FINISH
    } sched_state_e;

    localparam logic [1:0] POL_ALL  = 2'b00;
    localparam logic [1:0] POL_CONV = 2'b01;
    localparam logic [1:0] POL_PICK = 2'b10;
    localparam logic [1:0] POL_NONE = 2'b11;

    typedef struct packed {
        logic valid;
        logic fetch;
    } xfer_kind_t;

    function automatic logic policy_bit(input logic [1:0] mode,
                                        input logic       pick,
                                        input logic       conv);
        case (mode)
            POL_ALL:  return 1'b1;
            POL_CONV: return conv;
            POL_PICK: return pick;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/osch_policy.sv
module osch_policy
    import osch_pkg::*;
#(
    parameter int NUM_LAYERS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [1:0]            mode,
    input  logic [NUM_LAYERS-1:0] pick,
    input  logic [NUM_LAYERS-1:0] conv,
    output logic [NUM_LAYERS-1:0] eff
);

    logic [NUM_LAYERS-1:0] eff_next;

    for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_bit
        assign eff_next[i] = policy_bit(mode, pick[i], conv[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eff <= '0;
        end else if (load) begin
            eff <= eff_next;
        end
    end

endmodule

// File: rtl/osch_xfer_track.sv
module osch_xfer_track
    import osch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  xfer_kind_t req,
    input  logic       done,
    input  logic       done_fetch,
    output logic       off_pend,
    output logic       pf_pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_pend <= 1'b0;
            pf_pend  <= 1'b0;
        end else begin
            if (req.valid && !req.fetch) begin
                off_pend <= 1'b1;
            end else if (done && !done_fetch) begin
                off_pend <= 1'b0;
            end
            if (req.valid && req.fetch) begin
                pf_pend <= 1'b1;
            end else if (done && done_fetch) begin
                pf_pend <= 1'b0;
            end
        end
    end

    // R8: only one offload may be in flight at a time
    p_single_offload_r8: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !req.fetch) |-> !off_pend);

    // R8: only one fetch may be in flight at a time
    p_single_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.fetch) |-> !pf_pend);

endmodule

// File: rtl/osch_stall_cnt.sv
module osch_stall_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc_fwd,
    input  logic             inc_bwd,
    output logic [CNT_W-1:0] fwd_stall,
    output logic [CNT_W-1:0] bwd_stall
);

    localparam int LANES = 2;

    logic [LANES-1:0] inc;
    logic [CNT_W-1:0] cnt [LANES];

    assign inc = {inc_bwd, inc_fwd};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                cnt[k] <= '0;
            end else if (inc[k] && (cnt[k] != {CNT_W{1'b1}})) begin
                cnt[k] <= cnt[k] + CNT_W'(1);
            end
        end
    end

    assign fwd_stall = cnt[0];
    assign bwd_stall = cnt[1];

endmodule

// File: rtl/act_xfer_sched.sv
module act_xfer_sched
    import osch_pkg::*;
#(
    parameter int  NUM_LAYERS = 8,
    parameter int  CNT_W      = 16,
    localparam int IDX_W      = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            cfg_mode,
    input  logic [NUM_LAYERS-1:0] cfg_enable,
    input  logic [NUM_LAYERS-1:0] cfg_conv,
    output logic                  cmp_go,
    output logic                  cmp_bwd,
    output logic [IDX_W-1:0]      cmp_layer,
    input  logic                  cmp_done,
    output logic                  dma_req,
    output logic                  dma_fetch,
    output logic [IDX_W-1:0]      dma_layer,
    input  logic                  dma_done,
    input  logic                  dma_done_fetch,
    output logic                  busy,
    output logic                  iter_done,
    output logic [CNT_W-1:0]      fwd_stall,
    output logic [CNT_W-1:0]      bwd_stall
);

    localparam logic [IDX_W-1:0] TOP_LAYER = IDX_W'(NUM_LAYERS - 1);

    sched_state_e          st;
    logic [IDX_W-1:0]      cur;
    logic [IDX_W-1:0]      cur_lo;
    logic                  cmp_seen;
    logic                  fin_now;
    logic                  accept;
    logic                  off_pend;
    logic                  pf_pend;
    logic [NUM_LAYERS-1:0] eff;
    xfer_kind_t            kind;

    assign accept  = start && (st == ST_IDLE);
    assign fin_now = cmp_done || cmp_seen;
    assign cur_lo  = cur - IDX_W'(1);

    osch_policy #(.NUM_LAYERS(NUM_LAYERS)) u_policy (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .mode (cfg_mode),
        .pick (cfg_enable),
        .conv (cfg_conv),
        .eff  (eff)
    );

    assign kind.valid = dma_req;
    assign kind.fetch = dma_fetch;

    osch_xfer_track u_track (
        .clk        (clk),
        .rst        (rst),
        .req        (kind),
        .done       (dma_done),
        .done_fetch (dma_done_fetch),
        .off_pend   (off_pend),
        .pf_pend    (pf_pend)
    );

    osch_stall_cnt #(.CNT_W(CNT_W)) u_stall (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .inc_fwd   ((st == ST_FWD_RUN) && fin_now && off_pend),
        .inc_bwd   ((st == ST_BWD_WAIT) && pf_pend),
        .fwd_stall (fwd_stall),
        .bwd_stall (bwd_stall)
    );

    // Launch and request decode
    always_comb begin
        cmp_go    = 1'b0;
        cmp_bwd   = 1'b0;
        dma_req   = 1'b0;
        dma_fetch = 1'b0;
        dma_layer = cur;
        case (st)
            ST_FWD_ISSUE: begin
                cmp_go  = 1'b1;
                dma_req = eff[cur];
            end
            ST_BWD_PRE: begin
                dma_req   = eff[cur];
                dma_fetch = 1'b1;
            end
            ST_BWD_WAIT: begin
                cmp_bwd = 1'b1;
                if (!pf_pend) begin
                    cmp_go = 1'b1;
                    if (cur != '0) begin
                        dma_req   = eff[cur_lo];
                        dma_fetch = 1'b1;
                        dma_layer = cur_lo;
                    end
                end
            end
            ST_BWD_RUN: cmp_bwd = 1'b1;
            default: ;
        endcase
    end

    assign cmp_layer = cur;
    assign busy      = (st != ST_IDLE);
    assign iter_done = (st == ST_FINISH);

    // Layer sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur      <= '0;
            cmp_seen <= 1'b0;
        end else begin
            cmp_seen <= (st == ST_FWD_RUN) && fin_now && off_pend;
            case (st)
                ST_IDLE: if (accept) begin
                    st  <= ST_FWD_ISSUE;
                    cur <= '0;
                end
                ST_FWD_ISSUE: st <= ST_FWD_RUN;
                ST_FWD_RUN: if (fin_now && !off_pend) begin
                    if (cur == TOP_LAYER) begin
                        st <= ST_BWD_PRE;
                    end else begin
                        st  <= ST_FWD_ISSUE;
                        cur <= cur + IDX_W'(1);
                    end
                end
                ST_BWD_PRE: st <= ST_BWD_WAIT;
                ST_BWD_WAIT: if (!pf_pend) st <= ST_BWD_RUN;
                ST_BWD_RUN: if (cmp_done) begin
                    if (cur == '0) begin
                        st <= ST_FINISH;
                    end else begin
                        st  <= ST_BWD_WAIT;
                        cur <= cur_lo;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4: a forward launch never overlaps an unfinished offload
    p_fwd_after_offload_r4: assert property (@(posedge clk) disable iff (rst)
        (cmp_go && !cmp_bwd) |-> !off_pend);

    // R6: backward compute waits for its input fetch
    p_bwd_after_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        (cmp_go && cmp_bwd) |-> !pf_pend);

    // R7: disabled layers never reach the DMA port
    p_masked_layer_r7: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> eff[dma_layer]);

    // R9: completion is one cycle wide and returns to idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        iter_done |=> (!iter_done && !busy));

    // R1: nothing is launched or requested while idle
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cmp_go && !dma_req));

endmodule

// File: tb/test_act_xfer_sched.sv
module test_act_xfer_sched;

    localparam int L  = 8;
    localparam int IW = 3;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [L-1:0]  cfg_enable = '0;
    logic [L-1:0]  cfg_conv = '0;
    logic          cmp_go, cmp_bwd, dma_req, dma_fetch, busy, iter_done;
    logic [IW-1:0] cmp_layer, dma_layer;
    logic          cmp_done = 1'b0;
    logic          dma_done = 1'b0;
    logic          dma_done_fetch = 1'b0;
    logic [CW-1:0] fwd_stall, bwd_stall;

    always #10 clk = ~clk;

    act_xfer_sched #(.NUM_LAYERS(L), .CNT_W(CW)) i_act_xfer_sched (
        .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode),
        .cfg_enable(cfg_enable), .cfg_conv(cfg_conv),
        .cmp_go(cmp_go), .cmp_bwd(cmp_bwd), .cmp_layer(cmp_layer), .cmp_done(cmp_done),
        .dma_req(dma_req), .dma_fetch(dma_fetch), .dma_layer(dma_layer),
        .dma_done(dma_done), .dma_done_fetch(dma_done_fetch),
        .busy(busy), .iter_done(iter_done), .fwd_stall(fwd_stall), .bwd_stall(bwd_stall)
    );

    int nchk = 0;
    int nfail = 0;

    // responder state
    int lat_c = 1, lat_o = 1, lat_p = 1;
    int c_tmr = 0, o_tmr = 0, p_tmr = 0;
    int seq_idx = 0, order_err = 0, proto_err = 0, done_pulses = 0;
    int off_cnt [L];
    int pf_cnt  [L];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compute and DMA models: observe at falling edge, return done after fixed latency
    always @(negedge clk) begin
        cmp_done = 1'b0;
        dma_done = 1'b0;
        if (c_tmr > 0) begin
            c_tmr--;
            if (c_tmr == 0) cmp_done = 1'b1;
        end
        if (o_tmr > 0) begin
            o_tmr--;
            if (o_tmr == 0) begin dma_done = 1'b1; dma_done_fetch = 1'b0; end
        end
        if (p_tmr > 0) begin
            p_tmr--;
            if (p_tmr == 0) begin
                if (dma_done) proto_err++;
                dma_done = 1'b1; dma_done_fetch = 1'b1;
            end
        end
        if (iter_done) done_pulses++;
        if (cmp_go) begin
            if (seq_idx < L) begin
                if (cmp_bwd || int'(cmp_layer) != seq_idx) order_err++;
                if (o_tmr != 0) proto_err++;
            end else begin
                if (!cmp_bwd || int'(cmp_layer) != 2*L-1-seq_idx) order_err++;
                if (p_tmr != 0) proto_err++;
            end
            seq_idx++;
            if (c_tmr != 0) proto_err++;
            c_tmr = lat_c;
        end
        if (dma_req) begin
            if (dma_fetch) begin
                if (p_tmr != 0) proto_err++;
                pf_cnt[dma_layer]++;
                p_tmr = lat_p;
            end else begin
                if (o_tmr != 0) proto_err++;
                off_cnt[dma_layer]++;
                o_tmr = lat_o;
            end
        end
    end

    task automatic check_reset();
        @(negedge clk);
        chk(!busy && !iter_done, "R1 busy/done after reset", {busy, iter_done}, 0);
        chk(!cmp_go && !dma_req, "R1 go/req after reset", {cmp_go, dma_req}, 0);
        chk(fwd_stall == 0 && bwd_stall == 0, "R1 stall counters after reset",
            fwd_stall + bwd_stall, 0);
    endtask

    task automatic run_iter(input string name, input logic [1:0] mode, input logic [L-1:0] pick,
                            input logic [L-1:0] conv, input int c, input int d_o, input int d_p);
        logic [L-1:0] eff;
        int exp_f, exp_b, cyc, bad_off, bad_pf;
        case (mode)
            2'b00: eff = '1;
            2'b01: eff = conv;
            2'b10: eff = pick;
            default: eff = '0;
        endcase
        exp_f = 0;
        exp_b = eff[L-1] ? d_p : 0;
        for (int i = 0; i < L; i++) begin
            if (eff[i] && d_o - c + 1 > 0) exp_f += d_o - c + 1;
            if (i < L-1 && eff[i] && d_p - c > 0) exp_b += d_p - c;
        end
        @(negedge clk);
        lat_c = c; lat_o = d_o; lat_p = d_p;
        seq_idx = 0; order_err = 0; proto_err = 0; done_pulses = 0;
        for (int i = 0; i < L; i++) begin off_cnt[i] = 0; pf_cnt[i] = 0; end
        cfg_mode = mode; cfg_enable = pick; cfg_conv = conv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: scramble configuration after it was latched
        cfg_mode = ~mode; cfg_enable = ~pick; cfg_conv = ~conv;
        repeat (3) @(negedge clk);
        start = 1'b1;   // R9: ignored while busy
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!iter_done && cyc < 5000) begin @(negedge clk); cyc++; end
        chk(cyc < 5000, {name, " R9 iteration completes"}, cyc, 0);
        repeat (3) @(negedge clk);
        chk(done_pulses == 1, {name, " R9 single completion pulse"}, done_pulses, 1);
        chk(!busy, {name, " R9 idle after completion"}, busy, 0);
        chk(seq_idx == 2*L, {name, " R3 R5 launch count"}, seq_idx, 2*L);
        chk(order_err == 0, {name, " R3 R5 launch order"}, order_err, 0);
        chk(proto_err == 0, {name, " R4 R6 R8 overlap rules"}, proto_err, 0);
        bad_off = 0; bad_pf = 0;
        for (int i = 0; i < L; i++) begin
            if (off_cnt[i] != int'(eff[i])) bad_off++;
            if (pf_cnt[i] != int'(eff[i])) bad_pf++;
        end
        chk(bad_off == 0, {name, " R2 R7 offload per layer (mismatching layers)"}, bad_off, 0);
        chk(bad_pf == 0, {name, " R2 R7 fetch per layer (mismatching layers)"}, bad_pf, 0);
        chk(int'(fwd_stall) == exp_f, {name, " R4 forward stall cycles"}, fwd_stall, exp_f);
        chk(int'(bwd_stall) == exp_b, {name, " R6 backward stall cycles"}, bwd_stall, exp_b);
        cfg_mode = mode;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset();
        run_iter("all-slow-dma", 2'b00, 8'h00, 8'h00, 3, 6, 5);
        run_iter("conv-only", 2'b01, 8'hF0, 8'h0F, 5, 2, 8);
        run_iter("subset", 2'b10, 8'hA6, 8'h00, 2, 4, 3);
        run_iter("none", 2'b11, 8'hFF, 8'hFF, 4, 7, 7);
        run_iter("all-fast-dma", 2'b00, 8'h00, 8'h00, 4, 1, 1);
        run_iter("top-only", 2'b10, 8'h80, 8'h00, 1, 9, 9);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule